// File: doc/BRIEF.md
# Clock Page Replacement Engine

This block picks which physical page frame to give up when memory runs short. It keeps a recently-used flag and a modified flag for each of `NUM_FRAMES` frames and a single hand pointer that walks the frames as a ring. Every memory reference to a frame marks it as recently used, and a store also marks it as modified. When a replacement is needed, the hand walks the ring one frame per clock. Each recently-used frame it meets loses its flag and is skipped, which gives it a second chance. The first frame that is neither recently used nor modified becomes the victim. The victim is reported with its modified status so that the caller can schedule a write-back.

Modified frames that have not been used recently are passed over on the first lap, and the first of them is remembered. If a whole lap turns up no clean candidate, the remembered frame is chosen. A free-frame counter is kept from increment and decrement strobes and from the block's own victims. When that count falls below a programmable low threshold, sweeps run back to back until the count reaches a programmable high threshold. Disk traffic and page-table maintenance are left to the caller.

Top module: `clock_evict_engine`

## Requirements
- R1: After reset no victim is reported, `busy` and `batch_on` are low, the hand is at frame 0 and `free_count` equals `NUM_FRAMES`.
- R2: A reference (`ref_valid`) sets the used flag of `ref_frame`; when `ref_write` is 1 it also sets that frame's modified flag.
- R3: A sweep examines one frame per clock, starting at the hand. A frame whose used flag is set has the flag cleared and is passed over.
- R4: The first examined frame with both flags clear becomes the victim. `victim_valid` pulses for one cycle, in the cycle after that frame was examined, with `victim_frame` and `victim_dirty`. The victim's used and modified flags are then cleared.
- R5: After a victim is chosen, the hand points to the frame that follows it, with frame `NUM_FRAMES-1` followed by frame 0.
- R6: If every frame is used and clean, the sweep clears all the flags in one lap and selects the frame it started from, `NUM_FRAMES+1` scan cycles after the request.
- R7: On the first lap, a frame that is unused but modified is passed over and the first such frame is remembered. If the lap ends without a clean candidate, the remembered frame becomes the victim with `victim_dirty`=1.
- R8: If nothing was remembered on the first lap, the second lap takes the first unused frame whether or not it is modified.
- R9: A reference to the frame under examination, in the same cycle, wins over the clear: that frame keeps its used flag and is passed over.
- R10: Each cycle, `free_count` rises by 1 on `free_inc` and on each chosen victim, and falls by 1 on `free_dec`. It stays within 0..`NUM_FRAMES`, and `free_inc` together with `free_dec` leaves it unchanged.
- R11: When `free_count` falls below the low threshold, `batch_on` rises and sweeps repeat without any request until `free_count` reaches the high threshold. `batch_on` then falls.
- R12: `cfg_wr` loads `cfg_low` and `cfg_high` into the threshold registers. Their values after reset are `LOW_INIT` and `HIGH_INIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | A memory reference hits `ref_frame` this cycle |
| ref_frame | input | IW | Index of the referenced frame |
| ref_write | input | 1 | The reference is a store |
| evict_req | input | 1 | Request one replacement; taken when not busy |
| free_inc | input | 1 | One frame was released elsewhere |
| free_dec | input | 1 | One frame was allocated |
| cfg_wr | input | 1 | Load the threshold registers |
| cfg_low | input | CW | New low threshold |
| cfg_high | input | CW | New high threshold |
| victim_valid | output | 1 | One-cycle pulse: a victim was selected |
| victim_frame | output | IW | Index of the victim |
| victim_dirty | output | 1 | The victim needs a write-back |
| busy | output | 1 | A sweep is in progress |
| free_count | output | CW | Current free-frame count |
| batch_on | output | 1 | A watermark-driven batch of evictions is active |

## Verification
A processor reference and the hand's clear of the same frame can land in the same cycle. The bench provokes this by issuing a read of the start frame exactly in the first scan cycle of a sweep over a fully used ring. The verdict comes from the victim index and the scan-cycle count: frame 1 after ten cycles, where the same sweep without the reference gives frame 0 after nine. A second collision is also driven: free-count increment and decrement strobes in one cycle, which must leave the count unchanged.

// File: rtl/clk_evict_pkg.sv
`timescale 1ns/1ps
package clk_evict_pkg;
   typedef enum logic {
      SW_IDLE = 1'b0,
      SW_SCAN = 1'b1
   } sweep_st_e;
endpackage

// File: rtl/clk_frame_flags.sv
`timescale 1ns/1ps
// Per-frame used/modified flags. A reference always wins over a clear.
module clk_frame_flags #(
   parameter int N  = 8,
   localparam int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ref_valid,
   input  logic [IW-1:0] ref_frame,
   input  logic          ref_write,
   input  logic          clr_use,
   input  logic [IW-1:0] clr_idx,
   input  logic          take,
   input  logic [IW-1:0] take_idx,
   output logic [N-1:0]  use_vec,
   output logic [N-1:0]  dirty_vec
);
   for (genvar i = 0; i < N; i++) begin : g_frame
      logic u_q, d_q;
      logic hit;
      assign hit = ref_valid && (ref_frame == IW'(i));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            u_q <= 1'b0;
            d_q <= 1'b0;
         end else if (hit) begin
            u_q <= 1'b1;
            if (ref_write) d_q <= 1'b1;
         end else if (take && (take_idx == IW'(i))) begin
            u_q <= 1'b0;
            d_q <= 1'b0;
         end else if (clr_use && (clr_idx == IW'(i))) begin
            u_q <= 1'b0;
         end
      end
      assign use_vec[i]   = u_q;
      assign dirty_vec[i] = d_q;
   end
endmodule

// File: rtl/clk_sweep.sv
`timescale 1ns/1ps
// Hand pointer and sweep state machine, one frame per cycle.
module clk_sweep
   import clk_evict_pkg::*;
#(
   parameter int N          = 8,
   parameter bit SKIP_DIRTY = 1'b1,
   localparam int IW = $clog2(N),
   localparam int SW = $clog2(2*N+1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [N-1:0]  use_vec,
   input  logic [N-1:0]  dirty_vec,
   input  logic          ref_valid,
   input  logic [IW-1:0] ref_frame,
   output logic [IW-1:0] hand,
   output logic          clr_use,
   output logic          take,
   output logic [IW-1:0] take_idx,
   output logic          busy,
   output logic          victim_valid,
   output logic [IW-1:0] victim_frame,
   output logic          victim_dirty
);
   sweep_st_e     st_q;
   logic [IW-1:0] hand_q, mem_idx_q;
   logic [SW-1:0] steps_q;
   logic          mem_v_q;
   logic          skip_en, ref_here, eff_use, first_lap, lap_done;
   logic          advance, remember, take_dirty;

   function automatic logic [IW-1:0] nxt(input logic [IW-1:0] h);
      return (h == IW'(N-1)) ? '0 : h + IW'(1);
   endfunction

   if (SKIP_DIRTY) begin : g_clean_first
      assign skip_en = 1'b1;
   end else begin : g_plain_clock
      assign skip_en = 1'b0;
   end

   assign ref_here  = ref_valid && (ref_frame == hand_q);
   assign eff_use   = use_vec[hand_q] || ref_here;
   assign first_lap = steps_q < SW'(N);
   assign lap_done  = steps_q == SW'(N);

   always_comb begin
      clr_use    = 1'b0;
      take       = 1'b0;
      advance    = 1'b0;
      remember   = 1'b0;
      take_idx   = hand_q;
      take_dirty = dirty_vec[hand_q];
      if (st_q == SW_SCAN) begin
         if (lap_done && mem_v_q) begin
            take       = 1'b1;
            take_idx   = mem_idx_q;
            take_dirty = dirty_vec[mem_idx_q];
         end else if (eff_use) begin
            clr_use = 1'b1;
            advance = 1'b1;
         end else if (skip_en && first_lap && dirty_vec[hand_q]) begin
            advance  = 1'b1;
            remember = !mem_v_q;
         end else begin
            take = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= SW_IDLE;
         hand_q    <= '0;
         steps_q   <= '0;
         mem_v_q   <= 1'b0;
         mem_idx_q <= '0;
      end else if (st_q == SW_IDLE) begin
         if (start) begin
            st_q    <= SW_SCAN;
            steps_q <= '0;
            mem_v_q <= 1'b0;
         end
      end else begin
         if (advance) begin
            hand_q <= nxt(hand_q);
            if (steps_q != SW'(2*N)) steps_q <= steps_q + SW'(1);
         end
         if (remember) begin
            mem_v_q   <= 1'b1;
            mem_idx_q <= hand_q;
         end
         if (take) begin
            st_q   <= SW_IDLE;
            hand_q <= nxt(take_idx);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         victim_valid <= 1'b0;
         victim_frame <= '0;
         victim_dirty <= 1'b0;
      end else begin
         victim_valid <= take;
         if (take) begin
            victim_frame <= take_idx;
            victim_dirty <= take_dirty;
         end
      end
   end

   assign hand = hand_q;
   assign busy = (st_q == SW_SCAN);
endmodule

// File: rtl/clk_watermark.sv
`timescale 1ns/1ps
// Free-frame counter, threshold registers and batch trigger.
module clk_watermark #(
   parameter int N         = 8,
   parameter int LOW_INIT  = 2,
   parameter int HIGH_INIT = 4,
   localparam int CW = $clog2(N+1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          free_inc,
   input  logic          free_dec,
   input  logic          gain,
   input  logic          cfg_wr,
   input  logic [CW-1:0] cfg_low,
   input  logic [CW-1:0] cfg_high,
   output logic [CW-1:0] free_count,
   output logic [CW-1:0] hi_q,
   output logic          batch_on
);
   logic [CW-1:0] cnt_q, lo_q, cnt_nxt;
   logic [CW:0]   tmp;

   always_comb begin
      tmp = {1'b0, cnt_q} + {{CW{1'b0}}, free_inc} + {{CW{1'b0}}, gain};
      if (free_dec && (tmp != '0)) tmp = tmp - {{CW{1'b0}}, 1'b1};
      if (tmp > (CW+1)'(N)) tmp = (CW+1)'(N);
      cnt_nxt = tmp[CW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= CW'(N);
         lo_q     <= CW'(LOW_INIT);
         hi_q     <= CW'(HIGH_INIT);
         batch_on <= 1'b0;
      end else begin
         cnt_q    <= cnt_nxt;
         batch_on <= batch_on ? (cnt_nxt < hi_q) : (cnt_nxt < lo_q);
         if (cfg_wr) begin
            lo_q <= cfg_low;
            hi_q <= cfg_high;
         end
      end
   end

   assign free_count = cnt_q;
endmodule

// File: rtl/clock_evict_engine.sv
`timescale 1ns/1ps
module clock_evict_engine #(
   parameter int NUM_FRAMES = 8,
   parameter bit CLEAN_FIRST = 1'b1,
   parameter int LOW_INIT    = 2,
   parameter int HIGH_INIT   = 4,
   localparam int IW = $clog2(NUM_FRAMES),
   localparam int CW = $clog2(NUM_FRAMES+1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ref_valid,
   input  logic [IW-1:0] ref_frame,
   input  logic          ref_write,
   input  logic          evict_req,
   input  logic          free_inc,
   input  logic          free_dec,
   input  logic          cfg_wr,
   input  logic [CW-1:0] cfg_low,
   input  logic [CW-1:0] cfg_high,
   output logic          victim_valid,
   output logic [IW-1:0] victim_frame,
   output logic          victim_dirty,
   output logic          busy,
   output logic [CW-1:0] free_count,
   output logic          batch_on
);
   if (NUM_FRAMES < 2) begin : g_bad_n
      $error("NUM_FRAMES must be at least 2");
   end
   if (LOW_INIT > HIGH_INIT || HIGH_INIT > NUM_FRAMES) begin : g_bad_marks
      $error("thresholds must satisfy LOW_INIT <= HIGH_INIT <= NUM_FRAMES");
   end

   logic [NUM_FRAMES-1:0] use_vec, dirty_vec;
   logic [IW-1:0]         hand, take_idx;
   logic [CW-1:0]         hi_q;
   logic                  clr_use, take, start;

   assign start = evict_req || batch_on;

   clk_frame_flags #(.N(NUM_FRAMES)) u_flags (
      .clk(clk), .rst_n(rst_n),
      .ref_valid(ref_valid), .ref_frame(ref_frame), .ref_write(ref_write),
      .clr_use(clr_use), .clr_idx(hand),
      .take(take), .take_idx(take_idx),
      .use_vec(use_vec), .dirty_vec(dirty_vec)
   );

   clk_sweep #(.N(NUM_FRAMES), .SKIP_DIRTY(CLEAN_FIRST)) u_sweep (
      .clk(clk), .rst_n(rst_n), .start(start),
      .use_vec(use_vec), .dirty_vec(dirty_vec),
      .ref_valid(ref_valid), .ref_frame(ref_frame),
      .hand(hand), .clr_use(clr_use), .take(take), .take_idx(take_idx),
      .busy(busy), .victim_valid(victim_valid),
      .victim_frame(victim_frame), .victim_dirty(victim_dirty)
   );

   clk_watermark #(.N(NUM_FRAMES), .LOW_INIT(LOW_INIT), .HIGH_INIT(HIGH_INIT)) u_mark (
      .clk(clk), .rst_n(rst_n),
      .free_inc(free_inc), .free_dec(free_dec), .gain(take),
      .cfg_wr(cfg_wr), .cfg_low(cfg_low), .cfg_high(cfg_high),
      .free_count(free_count), .hi_q(hi_q), .batch_on(batch_on)
   );
endmodule

// File: rtl/clk_evict_chk.sv
`timescale 1ns/1ps
module clk_evict_chk #(
   parameter int N  = 8,
   localparam int IW = $clog2(N),
   localparam int CW = $clog2(N+1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ref_valid,
   input logic [IW-1:0] ref_frame,
   input logic          victim_valid,
   input logic [IW-1:0] victim_frame,
   input logic [IW-1:0] hand,
   input logic [N-1:0]  use_vec,
   input logic [CW-1:0] free_count,
   input logic [CW-1:0] hi_q,
   input logic          batch_on,
   input logic          free_inc,
   input logic          free_dec,
   input logic          busy
);
   a_r2_ref_sets_use: assert property (@(posedge clk) disable iff (!rst_n)
      ref_valid |=> use_vec[$past(ref_frame)]);

   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      victim_valid |=> !victim_valid);

   a_r5_hand_follows: assert property (@(posedge clk) disable iff (!rst_n)
      victim_valid |-> (hand == ((victim_frame == IW'(N-1)) ? '0 : victim_frame + IW'(1))));

   a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      free_count <= CW'(N));

   a_r10_cancel: assert property (@(posedge clk) disable iff (!rst_n)
      (free_inc && free_dec && !busy) |=> $stable(free_count));

   a_r11_batch_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(batch_on) |-> (free_count >= $past(hi_q)));
endmodule

bind clock_evict_engine clk_evict_chk #(.N(NUM_FRAMES)) u_chk (
   .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_frame(ref_frame),
   .victim_valid(victim_valid), .victim_frame(victim_frame), .hand(hand),
   .use_vec(use_vec), .free_count(free_count), .hi_q(hi_q),
   .batch_on(batch_on), .free_inc(free_inc), .free_dec(free_dec), .busy(busy)
);

// File: tb/tb_clock_evict_engine.sv
`timescale 1ns/1ps
module tb_clock_evict_engine;
   localparam int N  = 8;
   localparam int IW = $clog2(N);
   localparam int CW = $clog2(N+1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_valid = 1'b0, ref_write = 1'b0;
   logic [IW-1:0] ref_frame = '0;
   logic evict_req = 1'b0, free_inc = 1'b0, free_dec = 1'b0, cfg_wr = 1'b0;
   logic [CW-1:0] cfg_low = '0, cfg_high = '0;
   logic victim_valid, victim_dirty, busy, batch_on;
   logic [IW-1:0] victim_frame;
   logic [CW-1:0] free_count;

   int vectors = 0, miscompares = 0, cyc = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   clock_evict_engine #(.NUM_FRAMES(N)) dut (
      .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_frame(ref_frame),
      .ref_write(ref_write), .evict_req(evict_req), .free_inc(free_inc),
      .free_dec(free_dec), .cfg_wr(cfg_wr), .cfg_low(cfg_low), .cfg_high(cfg_high),
      .victim_valid(victim_valid), .victim_frame(victim_frame),
      .victim_dirty(victim_dirty), .busy(busy), .free_count(free_count),
      .batch_on(batch_on)
   );

   task automatic check(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; ref_valid = 1'b0; evict_req = 1'b0;
      free_inc = 1'b0; free_dec = 1'b0; cfg_wr = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic do_ref(input int f, input bit wr);
      @(negedge clk);
      ref_valid = 1'b1; ref_frame = IW'(f); ref_write = wr;
      @(negedge clk);
      ref_valid = 1'b0; ref_write = 1'b0;
   endtask

   // n = scan cycles until the victim pulse is seen
   task automatic do_evict(input bit inj, input int inj_f,
                           output int vf, output int vd, output int n);
      @(negedge clk); evict_req = 1'b1;
      @(negedge clk); evict_req = 1'b0;
      if (inj) begin ref_valid = 1'b1; ref_frame = IW'(inj_f); ref_write = 1'b0; end
      n = 0;
      while (!victim_valid && n < 100) begin
         @(negedge clk); ref_valid = 1'b0; n++;
      end
      vf = victim_frame; vd = victim_dirty;
   endtask

   task automatic t_reset();
      do_reset();
      @(negedge clk);
      check("R1 victim_valid", victim_valid, 0);
      check("R1 busy", busy, 0);
      check("R1 batch_on", batch_on, 0);
      check("R1 free_count", free_count, N);
   endtask

   task automatic t_fresh();
      int vf, vd, n;
      do_reset();
      do_evict(0, 0, vf, vd, n);
      check("R4 first victim frame", vf, 0);
      check("R4 first victim dirty", vd, 0);
      check("R4 latency", n, 1);
      do_evict(0, 0, vf, vd, n);
      check("R5 next victim after hand move", vf, 1);
   endtask

   task automatic t_second_chance();
      int vf, vd, n;
      do_reset();
      do_ref(0, 0); do_ref(1, 0);
      do_evict(0, 0, vf, vd, n);
      check("R3 skip used frames", vf, 2);
      check("R3 one frame per cycle", n, 3);
      for (int k = 3; k < N; k++) do_evict(0, 0, vf, vd, n);
      check("R5 wrap victim", vf, N-1);
      do_evict(0, 0, vf, vd, n);
      check("R3 cleared flag lets frame 0 go", vf, 0);
      check("R3 latency after wrap", n, 1);
   endtask

   task automatic t_all_used();
      int vf, vd, n;
      do_reset();
      for (int k = 0; k < N; k++) do_ref(k, 0);
      do_evict(0, 0, vf, vd, n);
      check("R6 full lap victim", vf, 0);
      check("R6 full lap cycles", n, N+1);
   endtask

   task automatic t_dirty();
      int vf, vd, n;
      do_reset();
      for (int k = 0; k < N; k++) do_ref(k, 1);
      do_evict(0, 0, vf, vd, n);
      check("R8 second lap victim", vf, 0);
      check("R8 R2 victim dirty", vd, 1);
      check("R8 cycles", n, N+1);
      do_ref(0, 0);
      do_evict(0, 0, vf, vd, n);
      check("R7 remembered dirty victim", vf, 1);
      check("R7 remembered dirty flag", vd, 1);
      check("R7 cycles", n, N+1);
      do_evict(0, 0, vf, vd, n);
      check("R7 clean frame preferred", vf, 0);
      check("R7 clean victim dirty", vd, 0);
      check("R7 clean latency", n, N-1);
   endtask

   task automatic t_collide();
      int vf, vd, n;
      do_reset();
      for (int k = 0; k < N; k++) do_ref(k, 0);
      do_evict(1, 0, vf, vd, n);
      check("R9 ref wins over clear victim", vf, 1);
      check("R9 ref wins cycles", n, N+2);
   endtask

   task automatic t_count();
      do_reset();
      @(negedge clk); free_inc = 1'b1;
      @(negedge clk); free_inc = 1'b0;
      check("R10 saturate at top", free_count, N);
      @(negedge clk); free_dec = 1'b1;
      @(negedge clk); free_dec = 1'b0;
      check("R10 decrement", free_count, N-1);
      @(negedge clk); free_inc = 1'b1; free_dec = 1'b1;
      @(negedge clk); free_inc = 1'b0; free_dec = 1'b0;
      check("R10 inc and dec cancel", free_count, N-1);
   endtask

   task automatic t_batch();
      int seen;
      do_reset();
      @(negedge clk); cfg_wr = 1'b1; cfg_low = CW'(3); cfg_high = CW'(5);
      @(negedge clk); cfg_wr = 1'b0;
      for (int k = 0; k < 5; k++) begin
         free_dec = 1'b1; @(negedge clk); free_dec = 1'b0; @(negedge clk);
      end
      check("R12 count at low mark", free_count, 3);
      check("R12 no batch at low mark", batch_on, 0);
      free_dec = 1'b1; @(negedge clk); free_dec = 1'b0;
      check("R11 batch starts below low", batch_on, 1);
      seen = 0;
      for (int k = 0; k < 60; k++) begin
         @(negedge clk);
         if (victim_valid) seen++;
      end
      check("R11 victims in batch", seen, 3);
      check("R11 count at high mark", free_count, 5);
      check("R11 batch ended", batch_on, 0);
      check("R11 engine idle", busy, 0);
   endtask

   initial begin
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
         end
      end
   end

   initial begin
      t_reset();
      t_fresh();
      t_second_chance();
      t_all_used();
      t_dirty();
      t_collide();
      t_count();
      t_batch();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule